// File: doc/BRIEF.md
# Cascadable LCD Segment Column Loader

This block is the digital core of an 80-column LCD segment driver. Display data arrives on a slow shift clock, either one bit per clock on a single serial pin or four bits per clock on four pins. The block gathers the data into 4-bit units. An address counter steps through a first-stage column latch and places each unit at the next group of columns. A falling edge on the line strobe copies the first-stage latch into a second-stage latch. The second-stage latch sets the per-column drive-level selects.

Several copies form a chain. Each copy accepts data only while its chip-disable input is low. When its last column is written, its cascade output falls, and that output enables the next copy. Each column output is a 2-bit code that picks one of four drive levels. The code is formed from the stored bit, the frame alternation input and a display-enable input. A compile-time parameter reverses the column-to-pin order. With it, two copies with opposite pin orders can sit on either side of a panel.

The shift clock and the strobe are sampled by the system clock `clk`. An edge of either takes effect on the first `clk` edge that samples the input low after a sample of high.

Top module: `seg_column_loader`

## Requirements
- R1: Shift data is captured only on a falling edge of `shift_clk`, on the first `clk` edge that samples it low after a high sample. A rising edge or a held level captures nothing.
- R2: With `par_mode` high, each falling edge takes a whole unit from `par_d` and `ser_d`. With `par_mode` low, only `ser_d` is used and `par_d` has no effect.
- R3: In parallel mode, within a unit, `par_d[0]` goes to the lowest column, `par_d[1]` to the next, `par_d[2]` to the third and `ser_d` to the highest. Units fill columns 0-3, then 4-7, and so on up to column 79.
- R4: In serial mode, the first bit of each group of four goes to the lowest column of that group. Columns are written only once four bits are complete. Fewer than four bits left pending at a strobe are discarded, and the columns they would have filled keep their old contents.
- R5: `cascade_out` is 1 after reset and while columns remain unwritten. It falls on the edge that writes the last unit and stays 0 until the next strobe.
- R6: While `chip_dis` is 1, or once all columns are written, shift edges change neither the stored columns nor the write position.
- R7: A falling edge of `line_strobe` copies the first-stage latch into the second stage. It also returns the write position and any pending serial bits to column 0, and raises `cascade_out`. First-stage contents are kept.
- R8: `drive_sel` changes only after a strobe, or when `alt_m` or `disp_en` changes.
- R9: Column codes are 0 = top level, 1 = upper middle, 2 = lower middle, 3 = bottom. With `disp_en` at 0, every column is 0. Otherwise the code is 1 for `alt_m`=0 and bit 0, 0 for `alt_m`=0 and bit 1, 2 for `alt_m`=1 and bit 0, and 3 for `alt_m`=1 and bit 1.
- R10: Pin p is `drive_sel[2p+1:2p]`. It carries column p when MIRROR=0 and column COLS-1-p when MIRROR=1.
- R11: The write position never passes COLS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Data shift clock; its falling edge captures data |
| line_strobe | input | 1 | Line strobe; its falling edge transfers the latch |
| chip_dis | input | 1 | 1 blocks data capture |
| par_mode | input | 1 | 1 = four bits per shift, 0 = serial |
| par_d | input | UNIT-1 | Lower bits of a parallel unit |
| ser_d | input | 1 | Serial data, or the top bit of a parallel unit |
| alt_m | input | 1 | Frame alternation phase |
| disp_en | input | 1 | 0 forces every column to the top level |
| cascade_out | output | 1 | 1 while loading; enables the next copy when low |
| drive_sel | output | 2*COLS | Per-pin 2-bit level-select codes |

## Verification
The bench builds two 80-column copies chained through the cascade pin. The first uses the normal column order and the second uses MIRROR=1. This exposes the hand-off between copies, the reversed pin mapping, and shifts that arrive after both copies are full. Both copies use the default 4-bit unit, so serial strings that break off partway through a unit show the discard of pending bits.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;

   typedef enum logic [1:0] {
      LV_TOP       = 2'd0,
      LV_UPPER_MID = 2'd1,
      LV_LOWER_MID = 2'd2,
      LV_BOTTOM    = 2'd3
   } lvl_t;

   // Level select for one column from stored bit, frame phase and display enable.
   function automatic lvl_t pick_level(input logic bit_on, input logic phase, input logic shown);
      lvl_t r;
      if (!shown)
         r = LV_TOP;
      else begin
         unique case ({phase, bit_on})
            2'b00:   r = LV_UPPER_MID;
            2'b01:   r = LV_TOP;
            2'b10:   r = LV_LOWER_MID;
            default: r = LV_BOTTOM;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/seg_fall_detect.sv
module seg_fall_detect #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level_i,
   output logic [W-1:0] fall_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_q <= '0;
      else
         prev_q <= level_i;
   end

   assign fall_o = prev_q & ~level_i;
endmodule

// File: rtl/seg_unit_packer.sv
module seg_unit_packer #(
   parameter int UNIT = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic            restart,
   input  logic            par_mode,
   input  logic [UNIT-2:0] par_d,
   input  logic            ser_d,
   output logic [UNIT-1:0] unit_o,
   output logic            unit_vld_o
);
   localparam int CW = (UNIT > 2) ? $clog2(UNIT) : 1;
   localparam logic [CW-1:0] LAST_IDX = CW'(UNIT - 1);

   logic [CW-1:0]   cnt_q;
   logic [UNIT-2:0] hold_w;
   logic            last;

   assign last = (cnt_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= '0;
      else if (step) begin
         if (par_mode || last)
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + 1'b1;
      end
   end

   // One holding cell per pending serial bit.
   for (genvar b = 0; b < UNIT - 1; b++) begin : g_hold
      logic cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= 1'b0;
         else if (step && !par_mode && cnt_q == CW'(b))
            cell_q <= ser_d;
      end
      assign hold_w[b] = cell_q;
   end

   assign unit_vld_o = step & (par_mode | last);
   assign unit_o     = par_mode ? {ser_d, par_d} : {ser_d, hold_w};
endmodule

// File: rtl/seg_column_store.sv
module seg_column_store #(
   parameter int COLS = 80,
   parameter int UNIT = 4,
   parameter int AW   = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [UNIT-1:0] wr_unit,
   input  logic            copy_en,
   output logic [AW-1:0]   addr_o,
   output logic [COLS-1:0] shown_o
);
   localparam int NGRP = COLS / UNIT;
   localparam logic [AW-1:0] STEP = AW'(UNIT);

   logic [AW-1:0]   addr_q;
   logic [COLS-1:0] stage1_w;
   logic [COLS-1:0] stage2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (copy_en)
         addr_q <= '0;
      else if (wr_en)
         addr_q <= addr_q + STEP;
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_unit
      localparam logic [AW-1:0] BASE = AW'(g * UNIT);
      logic [UNIT-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= '0;
         else if (wr_en && addr_q == BASE)
            cell_q <= wr_unit;
      end
      assign stage1_w[g*UNIT +: UNIT] = cell_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stage2_q <= '0;
      else if (copy_en)
         stage2_q <= stage1_w;
   end

   assign addr_o  = addr_q;
   assign shown_o = stage2_q;
endmodule

// File: rtl/seg_level_bank.sv
module seg_level_bank
   import seg_loader_pkg::*;
#(
   parameter int COLS   = 80,
   parameter bit MIRROR = 1'b0
) (
   input  logic [COLS-1:0]   shown_i,
   input  logic              alt_m,
   input  logic              disp_en,
   output logic [2*COLS-1:0] drive_o
);
   for (genvar p = 0; p < COLS; p++) begin : g_pin
      if (MIRROR) begin : g_rev
         assign drive_o[2*p +: 2] = pick_level(shown_i[COLS-1-p], alt_m, disp_en);
      end else begin : g_fwd
         assign drive_o[2*p +: 2] = pick_level(shown_i[p], alt_m, disp_en);
      end
   end
endmodule

// File: rtl/seg_column_loader.sv
module seg_column_loader #(
   parameter int COLS   = 80,
   parameter int UNIT   = 4,
   parameter bit MIRROR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_clk,
   input  logic              line_strobe,
   input  logic              chip_dis,
   input  logic              par_mode,
   input  logic [UNIT-2:0]   par_d,
   input  logic              ser_d,
   input  logic              alt_m,
   input  logic              disp_en,
   output logic              cascade_out,
   output logic [2*COLS-1:0] drive_sel
);
   localparam int AW = $clog2(COLS + 1);
   localparam logic [AW-1:0] FULL_AT = AW'(COLS);

   if (UNIT < 2) begin : g_bad_unit
      $error("UNIT must be at least 2");
   end
   if (COLS % UNIT != 0) begin : g_bad_cols
      $error("COLS must be a multiple of UNIT");
   end

   logic [1:0]      falls;
   logic            sh_fall;
   logic            ld_fall;
   logic            full;
   logic            step;
   logic [UNIT-1:0] unit_w;
   logic            unit_vld;
   logic [AW-1:0]   col_addr;
   logic [COLS-1:0] shown;

   seg_fall_detect #(.W(2)) u_edges (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i ({line_strobe, shift_clk}),
      .fall_o  (falls)
   );

   assign sh_fall = falls[0];
   assign ld_fall = falls[1];
   assign full    = (col_addr == FULL_AT);
   assign step    = sh_fall & ~chip_dis & ~full & ~ld_fall;

   seg_unit_packer #(.UNIT(UNIT)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step),
      .restart    (ld_fall),
      .par_mode   (par_mode),
      .par_d      (par_d),
      .ser_d      (ser_d),
      .unit_o     (unit_w),
      .unit_vld_o (unit_vld)
   );

   seg_column_store #(.COLS(COLS), .UNIT(UNIT), .AW(AW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (unit_vld),
      .wr_unit (unit_w),
      .copy_en (ld_fall),
      .addr_o  (col_addr),
      .shown_o (shown)
   );

   seg_level_bank #(.COLS(COLS), .MIRROR(MIRROR)) u_levels (
      .shown_i (shown),
      .alt_m   (alt_m),
      .disp_en (disp_en),
      .drive_o (drive_sel)
   );

   assign cascade_out = ~full;
endmodule

// File: rtl/seg_loader_checker.sv
module seg_loader_checker #(
   parameter int COLS = 80,
   parameter int AW   = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chip_dis,
   input logic              alt_m,
   input logic              disp_en,
   input logic              cascade_out,
   input logic [2*COLS-1:0] drive_sel,
   input logic              ld_fall,
   input logic [AW-1:0]     col_addr
);
   AST_BLANK_FORCES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_en |-> drive_sel == '0); // R9

   AST_DRIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(alt_m) && $stable(disp_en) && !$past(ld_fall)) |-> $stable(drive_sel)); // R8

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cascade_out && !ld_fall) |=> !cascade_out); // R5

   AST_STROBE_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
      ld_fall |=> cascade_out); // R7

   AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_dis && !ld_fall) |=> $stable(col_addr)); // R6

   AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      col_addr <= AW'(COLS)); // R11
endmodule

bind seg_column_loader seg_loader_checker #(.COLS(COLS), .AW($clog2(COLS + 1))) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .chip_dis    (chip_dis),
   .alt_m       (alt_m),
   .disp_en     (disp_en),
   .cascade_out (cascade_out),
   .drive_sel   (drive_sel),
   .ld_fall     (ld_fall),
   .col_addr    (col_addr)
);

// File: tb/test_seg_column_loader.sv
`timescale 1ns/1ps
module test_seg_column_loader;
   localparam int COLS = 80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shift_clk = 1'b0, line_strobe = 1'b0, chip_dis = 1'b0, par_mode = 1'b0;
   logic [2:0] par_d = '0;
   logic ser_d = 1'b0, alt_m = 1'b0, disp_en = 1'b1;
   logic casc_a, casc_b;
   logic [2*COLS-1:0] drv_a, drv_b;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   seg_column_loader #(.COLS(COLS), .UNIT(4), .MIRROR(1'b0)) i_seg_column_loader (
      .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .line_strobe(line_strobe),
      .chip_dis(chip_dis), .par_mode(par_mode), .par_d(par_d), .ser_d(ser_d),
      .alt_m(alt_m), .disp_en(disp_en), .cascade_out(casc_a), .drive_sel(drv_a));

   seg_column_loader #(.COLS(COLS), .UNIT(4), .MIRROR(1'b1)) i_seg_column_loader_mir (
      .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .line_strobe(line_strobe),
      .chip_dis(casc_a), .par_mode(par_mode), .par_d(par_d), .ser_d(ser_d),
      .alt_m(alt_m), .disp_en(disp_en), .cascade_out(casc_b), .drive_sel(drv_b));

   // Behavioural reference: two chained chips.
   bit s1 [2][COLS];
   bit s2 [2][COLS];
   int addr [2];
   int cnt [2];
   bit pend [2][4];

   function automatic logic [1:0] lvl(bit d, bit m, bit en);
      if (!en) return 2'd0;
      case ({m, d})
         2'b00: return 2'd1;
         2'b01: return 2'd0;
         2'b10: return 2'd2;
         default: return 2'd3;
      endcase
   endfunction

   function automatic logic [3:0] pat(int g);
      return 4'((g * 7 + 3) & 15);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_apply(input int c, input logic [3:0] v);
      if (par_mode) begin
         for (int k = 0; k < 4; k++) s1[c][addr[c] + k] = v[k];
         addr[c] += 4;
         cnt[c] = 0;
      end else begin
         pend[c][cnt[c]] = v[3];
         if (cnt[c] == 3) begin
            for (int k = 0; k < 4; k++) s1[c][addr[c] + k] = pend[c][k];
            addr[c] += 4;
            cnt[c] = 0;
         end else
            cnt[c]++;
      end
   endtask

   // One falling shift edge (R1): data is driven with the fall.
   task automatic shift(input logic [3:0] v);
      bit act_a, act_b;
      @(negedge clk) shift_clk = 1'b1;
      @(negedge clk) begin shift_clk = 1'b0; par_d = v[2:0]; ser_d = v[3]; end
      @(posedge clk);
      act_a = !chip_dis && addr[0] < COLS;
      act_b = (addr[0] == COLS) && addr[1] < COLS;
      if (act_a) model_apply(0, v);
      if (act_b) model_apply(1, v);
   endtask

   task automatic sbit(input bit b);
      shift({b, 3'($urandom)});
   endtask

   task automatic strobe();
      @(negedge clk) line_strobe = 1'b1;
      @(negedge clk) line_strobe = 1'b0;
      @(posedge clk);
      for (int c = 0; c < 2; c++) begin
         for (int k = 0; k < COLS; k++) s2[c][k] = s1[c][k];
         addr[c] = 0;
         cnt[c] = 0;
      end
   endtask

   task automatic settle();
      @(posedge clk); #1;
   endtask

   // Per-clock comparison against the reference (R1, R5, R8, R9, R10).
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         logic [2*COLS-1:0] ea, eb;
         for (int p = 0; p < COLS; p++) begin
            ea[2*p +: 2] = lvl(s2[0][p], alt_m, disp_en);
            eb[2*p +: 2] = lvl(s2[1][COLS-1-p], alt_m, disp_en);
         end
         checks += 4;
         if (drv_a !== ea) begin errors++; $display("FAIL R9 chip A drive actual=%0h expected=%0h", drv_a, ea); end
         if (drv_b !== eb) begin errors++; $display("FAIL R10 chip B drive actual=%0h expected=%0h", drv_b, eb); end
         if (casc_a !== (addr[0] != COLS)) begin errors++; $display("FAIL R5 chip A cascade actual=%0b expected=%0b", casc_a, addr[0] != COLS); end
         if (casc_b !== (addr[1] != COLS)) begin errors++; $display("FAIL R5 chip B cascade actual=%0b expected=%0b", casc_b, addr[1] != COLS); end
      end
   end

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int c = 0; c < 2; c++) begin addr[c] = 0; cnt[c] = 0; end
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      settle();
      check("R5 reset cascade", 32'(casc_a), 32'd1);
      check("R9 reset code", 32'(drv_a[1:0]), 32'd1);

      // Parallel fill of both chips (R2, R3, R5)
      par_mode = 1'b1;
      for (int g = 0; g < 20; g++) shift(pat(g));
      settle();
      check("R5 chip A full", 32'(casc_a), 32'd0);
      check("R5 chip B still loading", 32'(casc_b), 32'd1);
      for (int g = 20; g < 40; g++) shift(pat(g));
      settle();
      check("R5 chip B full", 32'(casc_b), 32'd0);
      for (int g = 0; g < 3; g++) shift(4'h0);   // R6 R11 shifts past full
      settle();
      check("R11 full stays", 32'(casc_a), 32'd0);
      strobe();
      settle();
      check("R7 cascade rearmed", 32'({casc_a, casc_b}), 32'd3);
      // pattern 3 -> columns 0,1 set; 2,3 clear
      check("R3 col0", 32'(drv_a[1:0]), 32'd0);
      check("R3 col2", 32'(drv_a[5:4]), 32'd1);
      check("R3 col3", 32'(drv_a[7:6]), 32'd1);
      check("R10 mirror pin79 is col0", 32'(drv_b[159:158]), 32'(lvl(pat(20)[0], 0, 1)));
      check("R10 mirror pin0 is col79", 32'(drv_b[1:0]), 32'(lvl(pat(39)[3], 0, 1)));

      // Encoding (R9)
      @(negedge clk) alt_m = 1'b1;
      settle();
      check("R9 m1 d1", 32'(drv_a[1:0]), 32'd3);
      check("R9 m1 d0", 32'(drv_a[5:4]), 32'd2);
      @(negedge clk) disp_en = 1'b0;
      settle();
      check("R9 blank", 32'(drv_a[1:0] | drv_a[5:4]), 32'd0);
      @(negedge clk) begin disp_en = 1'b1; alt_m = 1'b0; end

      // Serial with a trailing partial unit (R2, R4, R8)
      par_mode = 1'b0;
      sbit(1); sbit(0); sbit(1); sbit(1);
      sbit(0); sbit(0); sbit(1); sbit(0);
      sbit(1); sbit(1);
      settle();
      check("R8 held before strobe", 32'(drv_a[7:0]), 32'({2'd1, 2'd1, 2'd0, 2'd0}));
      strobe();
      settle();
      check("R4 first bit lowest", 32'(drv_a[7:0]), 32'({2'd0, 2'd0, 2'd1, 2'd0}));
      check("R4 second unit", 32'(drv_a[15:8]), 32'({2'd1, 2'd0, 2'd1, 2'd1}));
      check("R4 partial dropped", 32'(drv_a[19:16]), 32'({lvl(pat(2)[1], 0, 1), lvl(pat(2)[0], 0, 1)}));

      // Restart at column 0 after strobe (R7)
      sbit(0); sbit(0); sbit(0); sbit(0);
      strobe();
      settle();
      check("R7 restart col0", 32'(drv_a[7:0]), 32'h55);

      // Disabled chip ignores shifts (R6)
      chip_dis = 1'b1;
      par_mode = 1'b1;
      for (int g = 0; g < 5; g++) shift(4'hF);
      strobe();
      settle();
      check("R6 disabled unchanged", 32'(drv_a[7:0]), 32'h55);
      chip_dis = 1'b0;

      // Held high shift clock captures nothing (R1)
      @(negedge clk) begin shift_clk = 1'b1; par_d = 3'h7; ser_d = 1'b1; end
      repeat (5) @(posedge clk);
      strobe();
      settle();
      check("R1 no capture while high", 32'(drv_a[1:0]), 32'd1);
      @(negedge clk) shift_clk = 1'b0;
      @(posedge clk);
      model_apply(0, 4'hF);
      strobe();
      settle();
      check("R1 capture on fall", 32'(drv_a[7:0]), 32'h00);

      repeat (3) @(posedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule